// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmitter with Double Buffering

This block is the transmit half of a synchronous serial port. A processor or DMA engine writes a word into two 16-bit holding registers, a high half and a low half. The transmitter moves the held word into its own shift register when the shifter is free. On a frame sync it sends the word out MSB first on a single data pin, one bit per bit-clock tick. The bit clock comes in as a one-cycle enable `bit_tick` in the `clk` domain. The rising edge of the bit clock is the clock edge on which `bit_tick` is high.

Software paces itself on a ready flag and a one-cycle ready event, which can be used as an interrupt or DMA request. An empty flag reports underflow. When software falls behind, the block does not send garbage: every new frame sync repeats the word in the holding registers. The frame sync can come from the pin `fs_ext`. In self-framing mode the block makes its own frame pulse, one for each word it loads into the shifter. A low `tx_en` holds the transmitter in reset. Releasing it gives a defined start state.

Top module: `frame_serial_tx`

## Requirements
- R1: While `rst_n` is low, and on every clock where `tx_en` is low, the transmitter clears. After that clock, `tx_ready`=1, `tx_empty`=0, `dout`=0, `tx_event`=0 and `fs_out`=0, and both holding registers hold zero.
- R2: A write to the low half (`wr_lo`) drops `tx_ready` on the next clock. When the held word is later moved into the shifter, `tx_ready` returns to 1 and `tx_event` is high for exactly one clock.
- R3: Only a write to the low half commits a word, and it commits both halves together. Writing the high half alone changes neither `tx_ready` nor the shifter. In 32-bit mode, a high half that was not rewritten keeps its earlier value in the next word.
- R4: `wlen` picks the word length: 0 sends low[7:0] (8 bits), 1 sends low[15:0] (16 bits), 2 or 3 sends {high, low} (32 bits). Bits go out MSB first.
- R5: A frame has a one-bit data delay. On the start tick, `dout` is 0. Each of the next N ticks drives the next bit, and that bit holds until the following tick. `dout` changes only on a tick and is 0 whenever no frame is active.
- R6: With `self_frame`=0, a frame starts on a tick where `fs_ext` is high, provided no word is in the middle of being shifted. A tick at which the last bit is already on the pin counts as free. `fs_ext` pulses that arrive in the middle of a word are ignored.
- R7: With `self_frame`=1, each move of a word into the shifter raises `fs_out` for one clock, and the frame starts on the next tick. `fs_ext` is then ignored.
- R8: If the last bit of a word has gone out and no low-half write is pending, `tx_empty` falls on the clock after that tick. Each later external frame sync then resends the holding-register contents.
- R9: `tx_empty` returns to 1 on the clock after a newly written word moves into the shifter.
- R10: After reset, a frame sync that arrives before any low-half write sends an all-zero word.
- R11: A word written while another word is being shifted waits. `tx_ready` stays 0 until the last bit of the current word is on the pin, and the current word goes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low holds it in reset |
| self_frame | input | 1 | 1: generate a frame pulse on each shifter load |
| wlen | input | 2 | Word length select (0: 8, 1: 16, 2/3: 32 bits) |
| wr_lo | input | 1 | Write strobe for the low holding half |
| wr_hi | input | 1 | Write strobe for the high holding half |
| wr_data | input | 16 | Write data |
| bit_tick | input | 1 | Bit clock rising-edge enable |
| fs_ext | input | 1 | External frame sync, sampled on ticks |
| dout | output | 1 | Serial data |
| fs_out | output | 1 | Internally generated frame pulse |
| tx_ready | output | 1 | Holding register free for a new word |
| tx_event | output | 1 | One-clock pulse when `tx_ready` rises |
| tx_empty | output | 1 | Low while underflowed |

## Verification
Every result is registered, so each one is due at a fixed clock after its cause. A low-half write drops `tx_ready` one edge after the write edge. If the shifter is free, `tx_ready`, `tx_event`, `tx_empty` and `fs_out` change on the second edge. A new bit reaches `dout` on the edge of its tick, and the underflow drop of `tx_empty` lands on that same edge as the last bit. The bench drives inputs on falling edges and runs a queue-based reference model on rising edges. It compares all five outputs on each falling edge, so every result is checked at exactly the clock it is due. Directed checks collect the bits that `dout` carries after each tick and compare whole words built from the requirements.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    WL_8   = 2'd0,
    WL_16  = 2'd1,
    WL_32  = 2'd2,
    WL_32B = 2'd3
  } wlen_e;

  // number of data bits in one frame for a length code
  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] wl);
    case (wl)
      WL_8:    word_bits = CNT_W'(BYTE_W);
      WL_16:   word_bits = CNT_W'(HALF_W);
      default: word_bits = CNT_W'(WORD_W);
    endcase
  endfunction

  // place the selected bits MSB-aligned in the shifter width
  function automatic logic [WORD_W-1:0] align_word(input logic [HALF_W-1:0] hi,
                                                   input logic [HALF_W-1:0] lo,
                                                   input logic [1:0]        wl);
    case (wl)
      WL_8:    align_word = {lo[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
      WL_16:   align_word = {lo, {HALF_W{1'b0}}};
      default: align_word = {hi, lo};
    endcase
  endfunction
endpackage

// File: rtl/tx_holding.sv
module tx_holding
  import tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              copy_now,
  output logic [HALF_W-1:0] hold_hi,
  output logic [HALF_W-1:0] hold_lo,
  output logic              lo_fresh,
  output logic              ready,
  output logic              evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_hi  <= '0;
      hold_lo  <= '0;
      lo_fresh <= 1'b0;
      ready    <= 1'b1;
      evt      <= 1'b0;
    end else if (clr) begin
      hold_hi  <= '0;
      hold_lo  <= '0;
      lo_fresh <= 1'b0;
      ready    <= 1'b1;
      evt      <= 1'b0;
    end else begin
      if (wr_hi) hold_hi <= wr_data;
      if (wr_lo) hold_lo <= wr_data;
      // a new low write outranks a copy of the previous word
      if (wr_lo)         lo_fresh <= 1'b1;
      else if (copy_now) lo_fresh <= 1'b0;
      if (wr_lo)         ready <= 1'b0;
      else if (copy_now) ready <= 1'b1;
      evt <= copy_now & ~wr_lo;
    end
  end

  // R2
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n) evt |=> !evt);
  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !clr) |=> !ready);
endmodule

// File: rtl/tx_framer.sv
module tx_framer (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_tick,
  input  logic fs_ext,
  input  logic self_frame,
  input  logic copy_now,
  input  logic busy,
  output logic start,
  output logic fs_out
);
  logic self_req;

  assign start = bit_tick & ~busy & (self_frame ? self_req : fs_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      self_req <= 1'b0;
      fs_out   <= 1'b0;
    end else if (clr) begin
      self_req <= 1'b0;
      fs_out   <= 1'b0;
    end else begin
      if (copy_now && self_frame) self_req <= 1'b1;
      else if (start)             self_req <= 1'b0;
      fs_out <= copy_now & self_frame;
    end
  end

  // R7
  fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) fs_out |=> !fs_out);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_tick,
  input  logic              start,
  input  logic              copy_now,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  nbits,
  output logic              dout,
  output logic              busy,
  output logic              last_bit,
  output logic              sr_valid
);
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              active;

  assign busy     = active & (cnt != '0);
  assign last_bit = bit_tick & active & (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      dout     <= 1'b0;
      sr_valid <= 1'b0;
    end else if (clr) begin
      sr       <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      dout     <= 1'b0;
      sr_valid <= 1'b0;
    end else if (start) begin
      // a word staged earlier wins; otherwise send what is held now
      sr       <= (sr_valid && !copy_now) ? sr : load_word;
      cnt      <= nbits;
      active   <= 1'b1;
      dout     <= 1'b0;
      sr_valid <= 1'b0;
    end else begin
      if (bit_tick && active) begin
        if (cnt != '0) begin
          dout <= sr[WORD_W-1];
          sr   <= {sr[WORD_W-2:0], 1'b0};
          cnt  <= cnt - CNT_W'(1);
        end else begin
          active <= 1'b0;
          dout   <= 1'b0;
        end
      end
      if (copy_now) begin
        sr       <= load_word;
        sr_valid <= 1'b1;
      end
    end
  end

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !active |-> !dout);
  // R5
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !clr) |=> $stable(dout));
endmodule

// File: rtl/frame_serial_tx.sv
module frame_serial_tx
  import tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        self_frame,
  input  logic [1:0]  wlen,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [15:0] wr_data,
  input  logic        bit_tick,
  input  logic        fs_ext,
  output logic        dout,
  output logic        fs_out,
  output logic        tx_ready,
  output logic        tx_event,
  output logic        tx_empty
);
  logic              clr;
  logic [HALF_W-1:0] hold_hi, hold_lo;
  logic              lo_fresh;
  logic              copy_now, start, busy, last_bit, sr_valid;
  logic [WORD_W-1:0] load_word;
  logic [CNT_W-1:0]  nbits;

  assign clr       = ~tx_en;
  assign load_word = align_word(hold_hi, hold_lo, wlen);
  assign nbits     = word_bits(wlen);
  // move a fresh word only into a free, unstaged shifter
  assign copy_now  = lo_fresh & ~busy & ~sr_valid;

  tx_holding u_hold (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .copy_now(copy_now), .hold_hi(hold_hi), .hold_lo(hold_lo),
    .lo_fresh(lo_fresh), .ready(tx_ready), .evt(tx_event)
  );

  tx_framer u_frame (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_tick(bit_tick), .fs_ext(fs_ext),
    .self_frame(self_frame), .copy_now(copy_now), .busy(busy),
    .start(start), .fs_out(fs_out)
  );

  tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_tick(bit_tick), .start(start),
    .copy_now(copy_now), .load_word(load_word), .nbits(nbits), .dout(dout),
    .busy(busy), .last_bit(last_bit), .sr_valid(sr_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 tx_empty <= 1'b0;
    else if (clr)                               tx_empty <= 1'b0;
    else if (copy_now)                          tx_empty <= 1'b1;
    else if (last_bit && !lo_fresh && !wr_lo)   tx_empty <= 1'b0;
  end

  // R1
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (tx_ready && !tx_empty && !dout));
  // R9
  empty_on_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_now && tx_en) |=> tx_empty);
  // R8
  empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && last_bit && !lo_fresh && !wr_lo) |=> !tx_empty);
endmodule

// File: tb/test_frame_serial_tx.sv
module test_frame_serial_tx;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, tx_en = 1'b1, self_frame = 1'b0;
  logic [1:0]  wlen = 2'd1;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic        bit_tick = 1'b0, fs_ext = 1'b0;
  logic        dout, fs_out, tx_ready, tx_event, tx_empty;

  frame_serial_tx i_frame_serial_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .self_frame(self_frame), .wlen(wlen),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .bit_tick(bit_tick),
    .fs_ext(fs_ext), .dout(dout), .fs_out(fs_out), .tx_ready(tx_ready),
    .tx_event(tx_event), .tx_empty(tx_empty)
  );

  int n_checks = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  // reference model: the word in flight is a queue of bits
  function automatic int frame_len(input logic [1:0] wl);
    return (wl == 2'd0) ? 8 : (wl == 2'd1) ? 16 : 32;
  endfunction
  function automatic longint word_val(input logic [15:0] hi, input logic [15:0] lo,
                                      input logic [1:0] wl);
    if (wl == 2'd0) return longint'(lo & 16'h00FF);
    if (wl == 2'd1) return longint'(lo);
    return longint'({hi, lo});
  endfunction

  logic [15:0] m_lo = '0, m_hi = '0;
  bit m_fresh = 0, m_ready = 1, m_evt = 0, m_empty = 0, m_act = 0;
  bit m_dout = 0, m_fs = 0, m_req = 0, m_valid = 0;
  bit m_q[$];
  bit m_stage[$];

  always @(posedge clk) begin : model
    bit busy, cp, st, last;
    longint v;
    int n;
    if (!rst_n || !tx_en) begin
      m_lo = '0; m_hi = '0; m_fresh = 0; m_ready = 1; m_evt = 0; m_empty = 0;
      m_act = 0; m_dout = 0; m_fs = 0; m_req = 0; m_valid = 0;
      m_q.delete(); m_stage.delete();
    end else begin
      busy = m_act && (m_q.size() != 0);
      cp   = m_fresh && !busy && !m_valid;
      st   = bit_tick && !busy && (self_frame ? m_req : fs_ext);
      last = bit_tick && m_act && (m_q.size() == 1);
      n    = frame_len(wlen);
      v    = word_val(m_hi, m_lo, wlen);
      if (st) begin
        if (cp || !m_valid) begin
          m_q.delete();
          for (int i = n - 1; i >= 0; i--) m_q.push_back(v[i]);
        end else begin
          m_q = m_stage;
        end
        m_valid = 0; m_act = 1; m_dout = 0;
      end else begin
        if (bit_tick && m_act) begin
          if (m_q.size() != 0) m_dout = m_q.pop_front();
          else begin m_act = 0; m_dout = 0; end
        end
        if (cp) begin
          m_stage.delete();
          for (int i = n - 1; i >= 0; i--) m_stage.push_back(v[i]);
          m_valid = 1;
        end
      end
      if (cp && self_frame) m_req = 1;
      else if (st)          m_req = 0;
      m_fs  = cp && self_frame;
      m_evt = cp && !wr_lo;
      if (cp)                                m_empty = 1;
      else if (last && !m_fresh && !wr_lo)   m_empty = 0;
      if (wr_lo)   m_ready = 0;
      else if (cp) m_ready = 1;
      if (wr_lo)   m_fresh = 1;
      else if (cp) m_fresh = 0;
      if (wr_hi) m_hi = wr_data;
      if (wr_lo) m_lo = wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(dout == m_dout, "R5", "dout vs model", dout, m_dout);
      chk(tx_ready == m_ready, "R2", "ready vs model", tx_ready, m_ready);
      chk(tx_event == m_evt, "R2", "event vs model", tx_event, m_evt);
      chk(tx_empty == m_empty, "R8", "empty vs model", tx_empty, m_empty);
      chk(fs_out == m_fs, "R7", "fs_out vs model", fs_out, m_fs);
    end
  end

  // stimulus helpers
  task automatic do_tick(input bit fs, output bit d);
    @(negedge clk); bit_tick = 1'b1; fs_ext = fs;
    @(negedge clk); bit_tick = 1'b0; fs_ext = 1'b0; d = dout;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input bit hi, input logic [15:0] val);
    @(negedge clk); wr_hi = hi; wr_lo = !hi; wr_data = val;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic cap(input int n, input bit fs0, input bit fsmid, input int wr_at,
                     input logic [15:0] wv, output longint w);
    bit d;
    w = 0;
    do_tick(fs0, d);
    chk(d == 1'b0, "R5", "delay bit", d, 0);
    for (int i = 0; i < n; i++) begin
      if (i == wr_at) begin
        do_write(1'b0, wv);
        chk(tx_ready == 1'b0, "R11", "ready while shifting", tx_ready, 0);
      end
      do_tick(fsmid, d);
      w = {w[62:0], d};
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin : stim
    longint w;
    bit d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_ready == 1 && tx_empty == 0 && dout == 0 && tx_event == 0 && fs_out == 0,
        "R1", "reset state", {tx_ready, tx_empty, dout, tx_event, fs_out}, 5'b10000);

    // R10 frame sync before any write sends zeros
    cap(16, 1'b1, 1'b0, -1, 16'h0, w);
    chk(w == 0, "R10", "zero word", w, 0);

    // R2 / R9 write then copy
    do_write(1'b0, 16'hA5C3);
    chk(tx_ready == 0, "R2", "ready after low write", tx_ready, 0);
    @(negedge clk);
    chk(tx_ready == 1 && tx_event == 1, "R2", "ready/event on copy",
        {tx_ready, tx_event}, 2'b11);
    chk(tx_empty == 1, "R9", "empty high on copy", tx_empty, 1);
    @(negedge clk);
    chk(tx_event == 0, "R2", "event one clock", tx_event, 0);

    // R4 16-bit word, MSB first
    cap(16, 1'b1, 1'b0, -1, 16'h0, w);
    chk(w == 64'hA5C3, "R4", "16-bit word", w, 64'hA5C3);
    // R8 underflow: empty low, old word resent
    chk(tx_empty == 0, "R8", "empty low after last bit", tx_empty, 0);
    cap(16, 1'b1, 1'b0, -1, 16'h0, w);
    chk(w == 64'hA5C3, "R8", "stale word resent", w, 64'hA5C3);

    // R6 frame syncs in the middle of a word are ignored
    do_write(1'b0, 16'h3C96);
    cap(16, 1'b1, 1'b1, -1, 16'h0, w);
    chk(w == 64'h3C96, "R6", "mid-word syncs ignored", w, 64'h3C96);

    // R11 write while shifting waits for the word to finish
    cap(16, 1'b1, 1'b0, 5, 16'h1234, w);
    chk(w == 64'h3C96, "R11", "current word unchanged", w, 64'h3C96);
    chk(tx_empty == 1, "R11", "no underflow with pending write", tx_empty, 1);
    cap(16, 1'b1, 1'b0, -1, 16'h0, w);
    chk(w == 64'h1234, "R11", "pending word sent next", w, 64'h1234);

    // R3 / R4 32-bit, both halves, high kept when not rewritten
    wlen = 2'd2;
    do_write(1'b1, 16'hDEAD);
    chk(tx_ready == 1, "R3", "high write keeps ready", tx_ready, 1);
    do_write(1'b0, 16'hBEEF);
    cap(32, 1'b1, 1'b0, -1, 16'h0, w);
    chk(w == 64'hDEADBEEF, "R4", "32-bit word", w, 64'hDEADBEEF);
    do_write(1'b0, 16'h0001);
    cap(32, 1'b1, 1'b0, -1, 16'h0, w);
    chk(w == 64'hDEAD0001, "R3", "old high half reused", w, 64'hDEAD0001);

    // R4 8-bit word
    wlen = 2'd0;
    do_write(1'b0, 16'h7E81);
    cap(8, 1'b1, 1'b0, -1, 16'h0, w);
    chk(w == 64'h81, "R4", "8-bit word", w, 64'h81);

    // R7 self framing
    self_frame = 1'b1;
    do_write(1'b0, 16'h00F0);
    @(negedge clk);
    chk(fs_out == 1, "R7", "frame pulse on copy", fs_out, 1);
    @(negedge clk);
    chk(fs_out == 0, "R7", "frame pulse one clock", fs_out, 0);
    cap(8, 1'b0, 1'b0, -1, 16'h0, w);
    chk(w == 64'hF0, "R7", "self-framed word", w, 64'hF0);
    for (int i = 0; i < 4; i++) begin
      do_tick(1'b1, d);
      chk(d == 0, "R7", "external sync ignored", d, 0);
    end
    self_frame = 1'b0;

    // R1 restart, then R10 zeros before a write
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1 && tx_empty == 0, "R1", "held in reset",
        {tx_ready, tx_empty}, 2'b10);
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1 && tx_empty == 0, "R1", "after restart",
        {tx_ready, tx_empty}, 2'b10);
    cap(8, 1'b1, 1'b0, -1, 16'h0, w);
    chk(w == 0, "R10", "zeros after restart", w, 0);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule